// File: doc/BRIEF.md
# RAM-Backed Queue Controller

This controller turns a plain RAM with a single address port into a first-in first-out queue. A client raises `push_req` to store the word on the RAM data input, or `pop_req` to take the oldest stored word off the RAM data output. The controller drives the shared address bus and the active-high write strobe of the RAM. It tracks where the next word goes, where the oldest word sits and how many words are held.

One address bus serves both directions, so a cycle with both requests set can only carry out one of them. The pop wins, and the lost push is signalled on `push_refused` in that same cycle. A pop on an empty queue is signalled on `pop_refused`. A push on a full queue is also signalled on `push_refused`. The occupancy is held by a three-state machine with the states `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL`. Its named transitions are:

- `FIRST_IN`: `Q_EMPTY` to `Q_PARTIAL`.
- `LAST_SLOT`: `Q_PARTIAL` to `Q_FULL`.
- `FIRST_OUT`: `Q_FULL` to `Q_PARTIAL`.
- `LAST_OUT`: `Q_PARTIAL` to `Q_EMPTY`.
- `CLEAR`: any state to `Q_EMPTY`, taken on `init`.

`full` and `empty` are decoded straight from the state register.

Top module: `ramq_ctrl`

## Requirements
- R1: A cycle with `init` high clears the write position, the read position and the occupancy at the next rising edge. After that edge, `empty`=1, `full`=0 and `mem_addr`=0.
- R2: A push is accepted when `push_req`=1, `pop_req`=0, `init`=0 and `full`=0. In that cycle `mem_we`=1 and `mem_addr` carries the write position. That position then steps by one at the edge.
- R3: In every cycle without an accepted push, `mem_we`=0 and `mem_addr` carries the read position, so the RAM presents the oldest stored word.
- R4: Words read at accepted pops come out in the order they were written by accepted pushes.
- R5: When `push_req` and `pop_req` are both high and `init` is low, nothing is written and `push_refused`=1 in that cycle. The pop is carried out if the queue is not empty.
- R6: A push request while `full`=1 leaves `mem_we` low, raises `push_refused` and changes no position or occupancy.
- R7: A pop request while `empty`=1 raises `pop_refused` in that cycle, and `mem_addr` keeps the same read position after the edge.
- R8: With both requests low, `mem_we`, `push_refused` and `pop_refused` are all 0 and no flag or position changes.
- R9: `full` rises on the edge that brings the occupancy to 2**ADDR_W. `empty` rises on the edge that brings it to 0. Neither flag changes within a cycle.
- R10: Both positions wrap from 2**ADDR_W-1 to 0.
- R11: `init` overrides both requests. During `init`, `mem_we`=0, `push_refused` equals `push_req` and `pop_refused` equals `pop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| init | input | 1 | Synchronous clear, active high |
| push_req | input | 1 | Request to store a word |
| pop_req | input | 1 | Request to remove the oldest word |
| mem_addr | output | ADDR_W | Shared RAM address |
| mem_we | output | 1 | RAM write strobe, active high |
| full | output | 1 | Queue holds 2**ADDR_W words |
| empty | output | 1 | Queue holds no words |
| push_refused | output | 1 | Push requested but not carried out this cycle |
| pop_refused | output | 1 | Pop requested but not carried out this cycle |

## Verification
The bench goes after the push-and-pop collision on an empty queue, a partly filled queue and a full queue. A design that let the push win, or wrote on the collision, would corrupt the order or lose the oldest word. The bench fills past capacity and drains past empty. A design with a count one bit short, or with an unguarded write strobe, would overwrite the oldest word or walk the read position over stale data. The bench also runs several laps around the RAM to catch a wrap that lands on the wrong slot. It asserts `init` mid-stream with requests held high to show that the clear wins.

// File: rtl/ramq_pkg.sv
package ramq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_t;

    typedef struct packed {
        logic do_write;
        logic do_read;
        logic push_refused;
        logic pop_refused;
    } grant_t;

endpackage

// File: rtl/ramq_arbiter.sv
module ramq_arbiter
    import ramq_pkg::*;
(
    input  logic   init,
    input  logic   push_req,
    input  logic   pop_req,
    input  logic   full,
    input  logic   empty,
    output grant_t grant
);

    always_comb begin
        grant = '0;
        if (init) begin
            // clear wins: every request present is reported as not executed
            grant.push_refused = push_req;
            grant.pop_refused  = pop_req;
        end else begin
            // the pop owns the shared bus whenever it is requested
            grant.do_read      = pop_req && !empty;
            grant.pop_refused  = pop_req && empty;
            grant.do_write     = push_req && !pop_req && !full;
            grant.push_refused = push_req && (pop_req || full);
        end
    end

    // R5: a colliding push never reaches the RAM
    always_comb begin
        assert_collision_no_write_R5: assert (!(push_req && pop_req) || !grant.do_write);
    end

endmodule

// File: rtl/ramq_ptr.sv
module ramq_ptr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         advance,
    output logic [W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (clear)
            ptr <= '0;
        else if (advance)
            ptr <= ptr + W'(1);
    end

    // R10: each step lands on the next slot, wrapping modulo 2**W
    assert_step_wraps_R10: assert property (@(posedge clk) disable iff (clear)
        advance |=> ptr == W'($past(ptr) + W'(1)));

    // R7: no step means the position holds
    assert_hold_without_step_R7: assert property (@(posedge clk) disable iff (clear)
        !advance |=> $stable(ptr));

endmodule

// File: rtl/ramq_occupancy.sv
module ramq_occupancy
    import ramq_pkg::*;
#(
    parameter int N = 3
) (
    input  logic clk,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic empty
);

    localparam int           CW    = N + 1;
    localparam logic [CW-1:0] CAP  = CW'(1) << N;
    localparam logic [CW-1:0] ONE  = CW'(1);

    qstate_t         state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CW'(inc) - CW'(dec);
        if (clear) begin
            state_d = Q_EMPTY;                           // CLEAR
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                Q_EMPTY: begin
                    if (inc) state_d = Q_PARTIAL;        // FIRST_IN
                end
                Q_PARTIAL: begin
                    if (inc && cnt_q == CAP - ONE)
                        state_d = Q_FULL;                // LAST_SLOT
                    else if (dec && cnt_q == ONE)
                        state_d = Q_EMPTY;               // LAST_OUT
                end
                Q_FULL: begin
                    if (dec) state_d = Q_PARTIAL;        // FIRST_OUT
                end
                default: state_d = Q_EMPTY;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    // output process
    always_comb begin
        full  = (state_q == Q_FULL);
        empty = (state_q == Q_EMPTY);
    end

    // R9: occupancy never exceeds the RAM depth
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (clear)
        cnt_q <= CAP);

    // R9: flags agree with the count
    assert_full_means_cap_R9: assert property (@(posedge clk) disable iff (clear)
        full |-> cnt_q == CAP);
    assert_empty_means_zero_R9: assert property (@(posedge clk) disable iff (clear)
        empty |-> cnt_q == '0);

    // R6 / R7: no step past either end
    assert_no_inc_when_full_R6: assert property (@(posedge clk) disable iff (clear)
        full |-> !inc);
    assert_no_dec_when_empty_R7: assert property (@(posedge clk) disable iff (clear)
        empty |-> !dec);

    // R1: clear leaves the queue empty
    assert_clear_empties_R1: assert property (@(posedge clk)
        clear |=> empty && !full);

endmodule

// File: rtl/ramq_ctrl.sv
module ramq_ctrl
    import ramq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              init,
    input  logic              push_req,
    input  logic              pop_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              full,
    output logic              empty,
    output logic              push_refused,
    output logic              pop_refused
);

    grant_t            grant;
    logic [ADDR_W-1:0] wr_pos;
    logic [ADDR_W-1:0] rd_pos;

    ramq_arbiter u_arb (
        .init     (init),
        .push_req (push_req),
        .pop_req  (pop_req),
        .full     (full),
        .empty    (empty),
        .grant    (grant)
    );

    ramq_ptr #(.W(ADDR_W)) u_wr_ptr (
        .clk     (clk),
        .clear   (init),
        .advance (grant.do_write),
        .ptr     (wr_pos)
    );

    ramq_ptr #(.W(ADDR_W)) u_rd_ptr (
        .clk     (clk),
        .clear   (init),
        .advance (grant.do_read),
        .ptr     (rd_pos)
    );

    ramq_occupancy #(.N(ADDR_W)) u_occ (
        .clk   (clk),
        .clear (init),
        .inc   (grant.do_write),
        .dec   (grant.do_read),
        .full  (full),
        .empty (empty)
    );

    // shared bus: write position only while a write is granted
    always_comb begin
        mem_we       = grant.do_write;
        mem_addr     = grant.do_write ? wr_pos : rd_pos;
        push_refused = grant.push_refused;
        pop_refused  = grant.pop_refused;
    end

    // R6: the strobe is never raised into a full queue
    assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (init)
        mem_we |-> !full);

    // R8: an idle cycle reports nothing
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (init)
        (!push_req && !pop_req) |-> !mem_we && !push_refused && !pop_refused);

    // R11: clear blocks the strobe
    assert_init_blocks_write_R11: assert property (@(posedge clk)
        init |-> !mem_we);

    // R8: idle cycles leave flags alone
    assert_idle_flags_stable_R8: assert property (@(posedge clk) disable iff (init)
        (!push_req && !pop_req) |=> $stable(full) && $stable(empty));

endmodule

// File: tb/ramq_ctrl_test.sv
module ramq_ctrl_test;

    localparam int AW    = 3;
    localparam int DW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          init = 1'b1;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, full, empty, push_refused, pop_refused;

    logic [DW-1:0] ram   [DEPTH];
    logic [DW-1:0] qdata [DEPTH];
    int mcount = 0, mwr = 0, mrd = 0;
    int checks = 0, failures = 0;
    logic [DW-1:0] seed = 5'd1;

    always #4 clk = ~clk;

    ramq_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .init(init), .push_req(push_req), .pop_req(pop_req),
        .mem_addr(mem_addr), .mem_we(mem_we), .full(full), .empty(empty),
        .push_refused(push_refused), .pop_refused(pop_refused)
    );

    always @(posedge clk) if (mem_we) ram[mem_addr] <= din;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check mid-phase, update model at edge
    task automatic step(bit i, bit p, bit q, string req);
        bit ewe, enp, enq, erd;
        int eaddr;
        init = i; push_req = p; pop_req = q; din = seed;
        #1;
        chk(req, "full", int'(full), int'(mcount == DEPTH));
        chk(req, "empty", int'(empty), int'(mcount == 0));
        if (i) begin
            ewe = 0; enp = p; enq = q; erd = 0;
        end else begin
            erd = q && mcount > 0;
            enq = q && mcount == 0;
            ewe = p && !q && mcount < DEPTH;
            enp = p && (q || mcount == DEPTH);
        end
        eaddr = ewe ? mwr : mrd;
        chk(req, "mem_we", int'(mem_we), int'(ewe));
        chk(req, "push_refused", int'(push_refused), int'(enp));
        chk(req, "pop_refused", int'(pop_refused), int'(enq));
        chk(req, "mem_addr", int'(mem_addr), eaddr);
        if (erd) chk(req, "read data", int'(ram[mem_addr]), int'(qdata[mrd]));
        @(posedge clk);
        if (i) begin
            mcount = 0; mwr = 0; mrd = 0;
        end else begin
            if (ewe) begin qdata[mwr] = seed; mwr = (mwr + 1) % DEPTH; mcount++; end
            if (erd) begin mrd = (mrd + 1) % DEPTH; mcount--; end
        end
        seed = seed * 5'd3 + 5'd7;
        @(negedge clk);
    endtask

    task automatic t_reset();            // R1
        step(1, 0, 0, "R1");
        step(1, 0, 0, "R1");
        step(0, 0, 0, "R1");
        chk("R1", "addr after clear", int'(mem_addr), 0);
    endtask

    task automatic t_fill();             // R2, R9
        for (int k = 0; k < DEPTH; k++) step(0, 1, 0, "R2");
        chk("R9", "full after fill", int'(full), 1);
    endtask

    task automatic t_push_full();        // R6
        step(0, 1, 0, "R6");
        step(0, 1, 0, "R6");
    endtask

    task automatic t_drain();            // R3, R4, R9
        for (int k = 0; k < DEPTH; k++) step(0, 0, 1, "R4");
        chk("R9", "empty after drain", int'(empty), 1);
        step(0, 0, 0, "R3");
    endtask

    task automatic t_pop_empty();        // R7
        int a0;
        a0 = int'(mem_addr);
        step(0, 0, 1, "R7");
        chk("R7", "read position held", int'(mem_addr), a0);
    endtask

    task automatic t_collide();          // R5
        step(0, 1, 1, "R5");             // empty: both refused
        step(0, 1, 0, "R5");
        step(0, 1, 0, "R5");
        step(0, 1, 1, "R5");             // pop wins
        for (int k = 0; k < DEPTH; k++) step(0, 1, 0, "R5");
        step(0, 1, 1, "R5");             // full: pop wins
        step(0, 1, 0, "R5");
    endtask

    task automatic t_idle();             // R8
        for (int k = 0; k < 3; k++) step(0, 0, 0, "R8");
    endtask

    task automatic t_wrap();             // R10
        for (int lap = 0; lap < 3 * DEPTH; lap++) begin
            step(0, 1, 0, "R10");
            step(0, 1, 0, "R10");
            step(0, 0, 1, "R10");
        end
        while (mcount > 0) step(0, 0, 1, "R10");
    endtask

    task automatic t_init_mid();         // R11
        step(0, 1, 0, "R11");
        step(0, 1, 0, "R11");
        step(1, 1, 1, "R11");
        step(1, 1, 0, "R11");
        step(0, 0, 0, "R11");
        chk("R11", "empty after clear", int'(empty), 1);
        step(0, 1, 0, "R11");
        step(0, 0, 1, "R11");
    endtask

    bit done = 0;

    initial begin
        @(negedge clk);
        t_reset();
        t_pop_empty();
        t_fill();
        t_push_full();
        t_idle();
        t_drain();
        t_pop_empty();
        t_collide();
        t_idle();
        while (mcount > 0) step(0, 0, 1, "R4");
        t_wrap();
        t_init_mid();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule